// File: doc/BRIEF.md
# Byte Manipulation Unit

This unit performs byte-granular rework of a 64-bit operand A for unaligned load and store sequences and for byte-oriented string code. A second 64-bit operand B has two uses. Its low three bits give a byte offset, or its low eight bits give a per-byte lane mask. The operations are:

- clearing whole bytes under a lane mask;
- a family of mask, extract and insert operations, each in a low and a high form, for byte, word, longword and quadword sizes;
- an unsigned compare across the eight byte lanes.

Each operation is computed combinationally from the inputs presented with `in_valid`. The result is captured in an output register, so it appears one clock later together with `out_valid`. The unaligned operations are built from two parts. The first is a shift of A by eight times the offset, or by 64 minus that amount (taken modulo 64). The second is a byte-keep or byte-clear pattern. That pattern comes from a size pattern shifted left by the offset. Its low eight bits serve the low forms, and the bits that overflow past lane 7 serve the high forms.

Top module: `byte_manip_unit`

## Requirements
- R1: While `rst_n` is low and after its release with no valid input, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_result` keeps its previous value.
- R3: Opcode encoding is op[4] = high form, op[3:2] = class (00 misc, 01 mask, 10 extract, 11 insert), op[1:0] = size (0 byte, 1 word, 2 longword, 3 quadword; size patterns 0x01, 0x03, 0x0F, 0xFF). Misc op 0 clears each byte i of A whose B bit i is 1. Misc op 1 clears each byte whose B bit i is 0.
- R4: Mask-low clears byte i of A when bit i of (pattern << off) is set, where off = B[2:0].
- R5: Mask-high clears byte i of A when bit i+8 of (pattern << off) is set.
- R6: Extract-low yields A >> (8*off) with only the low 1, 2, 4 or 8 bytes kept, per size.
- R7: Extract-high yields A << ((64 - 8*off) mod 64) with only the low 1, 2, 4 or 8 bytes kept. An offset of 0 therefore shifts by 0.
- R8: Insert-low yields A << (8*off) with only the bytes set in the low 8 bits of (pattern << off) kept.
- R9: Insert-high yields A >> ((64 - 8*off) mod 64) with only the bytes set in bits 15:8 of (pattern << off) kept. An offset of 0 gives all zeros.
- R10: Misc op 2 sets result bit i (i = 0..7) when byte i of A is greater than or equal to byte i of B, unsigned. Result bits 63:8 are zero.
- R11: Misc op 3, and any opcode with op[4] = 1 and class 00, yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| in_op | input | 5 | Opcode: high flag, class, size |
| in_a | input | 64 | Data operand |
| in_b | input | 64 | Offset (bits 2:0) or lane mask (bits 7:0) or compare operand |
| out_valid | output | 1 | Result register loaded last cycle |
| out_result | output | 64 | Registered result |

## Verification
A wrong lane pattern from the size/offset generator shows up as a wrong byte in the very next `out_result`. Typical cases are a spill bit lost between the low and high halves, or a pattern of the wrong width. The corruption is confined to lanes near the offset boundary, so every offset from 0 to 7 is swept for every size in both forms. A wrong complementary shift amount appears only in the high forms, and most sharply at offset 0, where extract-high must return the unshifted low bytes and insert-high must return zero. A broken compare lane flips a single low result bit. Because the output register loads only on valid cycles, a faulty load enable shows up as a changed result during idle cycles.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int unsigned BMU_DATA_W = 64;
  localparam int unsigned BMU_BYTE_W = 8;
  localparam int unsigned BMU_LANES  = BMU_DATA_W / BMU_BYTE_W;
  localparam int unsigned BMU_OFF_W  = $clog2(BMU_LANES);
  localparam int unsigned BMU_OP_W   = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } bmu_size_e;

  typedef enum logic [1:0] {
    CLS_MISC = 2'd0,
    CLS_MASK = 2'd1,
    CLS_EXT  = 2'd2,
    CLS_INS  = 2'd3
  } bmu_class_e;

  localparam logic [1:0] MISC_ZAP    = 2'd0;
  localparam logic [1:0] MISC_ZAPNOT = 2'd1;
  localparam logic [1:0] MISC_CMPGE  = 2'd2;
  localparam logic [1:0] MISC_RSVD   = 2'd3;

  typedef struct packed {
    logic       high;
    bmu_class_e cls;
    bmu_size_e  size;
  } bmu_op_t;

  // Contiguous run of 2**size ones in the low lanes.
  function automatic logic [BMU_LANES-1:0] size_pattern(bmu_size_e s);
    logic [BMU_LANES:0] run;
    run = (BMU_LANES+1)'(1) << (1 << s);
    return BMU_LANES'(run - (BMU_LANES+1)'(1));
  endfunction

endpackage

// File: rtl/bmu_lane_mask.sv
module bmu_lane_mask
  import bmu_pkg::*;
#(
  parameter int unsigned LANES = BMU_LANES,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bmu_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] pat,
  output logic [LANES-1:0] low_m,
  output logic [LANES-1:0] high_m
);

  logic [2*LANES-1:0] span;

  always_comb begin
    pat    = size_pattern(size);
    span   = {{LANES{1'b0}}, pat} << off;
    low_m  = span[LANES-1:0];
    high_m = span[2*LANES-1:LANES];
  end

  // The split into low and spill halves must not lose or invent a lane.
  AST_LANE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(low_m) + $countones(high_m)) == $countones(pat)); // R5

  // At offset zero nothing spills into the high half.
  AST_NO_SPILL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (off == '0) |-> (high_m == '0)); // R9

endmodule

// File: rtl/bmu_shift_unit.sv
module bmu_shift_unit
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = BMU_DATA_W,
  parameter int unsigned BYTE_W = BMU_BYTE_W,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] up_by_off,
  output logic [DATA_W-1:0] down_by_off,
  output logic [DATA_W-1:0] up_by_comp,
  output logic [DATA_W-1:0] down_by_comp
);

  logic [SH_W-1:0] amt;
  logic [SH_W-1:0] comp_amt;

  always_comb begin
    amt          = SH_W'(off) << $clog2(BYTE_W);
    // Two's complement in SH_W bits is (DATA_W - amt) mod DATA_W.
    comp_amt     = SH_W'(0) - amt;
    up_by_off    = a << amt;
    down_by_off  = a >> amt;
    up_by_comp   = a << comp_amt;
    down_by_comp = a >> comp_amt;
  end

endmodule

// File: rtl/bmu_byte_cmp.sv
module bmu_byte_cmp
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = BMU_DATA_W,
  parameter int unsigned BYTE_W = BMU_BYTE_W,
  localparam int unsigned LANES = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [LANES-1:0]  ge
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] la;
    logic [BYTE_W-1:0] lb;
    assign la    = a[g*BYTE_W +: BYTE_W];
    assign lb    = b[g*BYTE_W +: BYTE_W];
    assign ge[g] = (la >= lb);
  end

endmodule

// File: rtl/byte_manip_unit.sv
module byte_manip_unit
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = BMU_DATA_W,
  parameter int unsigned BYTE_W = BMU_BYTE_W,
  parameter int unsigned OP_W   = BMU_OP_W,
  localparam int unsigned LANES = DATA_W / BYTE_W,
  localparam int unsigned OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  // Expand one keep bit per lane into a full-width bit mask.
  function automatic logic [DATA_W-1:0] lane_expand(logic [LANES-1:0] keep);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      m[i*BYTE_W +: BYTE_W] = {BYTE_W{keep[i]}};
    end
    return m;
  endfunction

  bmu_op_t          op;
  logic [OFF_W-1:0] off;
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] pat, low_m, high_m;
  logic [LANES-1:0] cmp_ge;
  logic [DATA_W-1:0] up_by_off, down_by_off, up_by_comp, down_by_comp;

  // Named decode events, used by the assertions below.
  logic is_reserved;
  logic is_cmp;
  logic is_zap_all;
  logic is_ins_high_zero;

  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;

  assign op       = bmu_op_t'(in_op);
  assign off      = in_b[OFF_W-1:0];
  assign lane_sel = in_b[LANES-1:0];

  bmu_lane_mask #(.LANES(LANES)) u_lane_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .size   (op.size),
    .off    (off),
    .pat    (pat),
    .low_m  (low_m),
    .high_m (high_m)
  );

  bmu_shift_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shift (
    .a            (in_a),
    .off          (off),
    .up_by_off    (up_by_off),
    .down_by_off  (down_by_off),
    .up_by_comp   (up_by_comp),
    .down_by_comp (down_by_comp)
  );

  bmu_byte_cmp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_cmp (
    .a  (in_a),
    .b  (in_b),
    .ge (cmp_ge)
  );

  assign is_reserved      = (op.cls == CLS_MISC) && (op.high || (op.size == MISC_RSVD));
  assign is_cmp           = (op.cls == CLS_MISC) && !op.high && (op.size == MISC_CMPGE);
  assign is_zap_all       = (op.cls == CLS_MISC) && !op.high && (op.size == MISC_ZAP)
                            && (lane_sel == '1);
  assign is_ins_high_zero = (op.cls == CLS_INS) && op.high && (off == '0);

  always_comb begin
    res_d = '0;
    unique case (op.cls)
      CLS_MISC: begin
        if (!op.high) begin
          unique case (op.size)
            MISC_ZAP:    res_d = in_a & ~lane_expand(lane_sel);
            MISC_ZAPNOT: res_d = in_a &  lane_expand(lane_sel);
            MISC_CMPGE:  res_d = DATA_W'(cmp_ge);
            default:     res_d = '0;
          endcase
        end
      end
      CLS_MASK: res_d = in_a & ~lane_expand(op.high ? high_m : low_m);
      CLS_EXT:  res_d = (op.high ? up_by_comp : down_by_off) & lane_expand(pat);
      CLS_INS:  res_d = op.high ? (down_by_comp & lane_expand(high_m))
                                : (up_by_off   & lane_expand(low_m));
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R2

  AST_ZAP_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_zap_all) |=> (out_result == '0)); // R3

  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> (out_result[DATA_W-1:LANES] == '0)); // R10

  AST_INS_HIGH_OFF0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_ins_high_zero) |=> (out_result == '0)); // R9

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_reserved) |=> (out_result == '0)); // R11

endmodule

// File: tb/test_byte_manip_unit.sv
module test_byte_manip_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;
  bit have_last = 1'b0;
  logic [63:0] last_exp = '0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  byte_manip_unit i_byte_manip_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  function automatic logic [7:0] get_byte(logic [63:0] v, int i);
    return v[i*8 +: 8];
  endfunction

  // Lane-by-lane restatement of the requirements.
  function automatic logic [63:0] ref_model(logic [4:0] op, logic [63:0] a,
                                            logic [63:0] b, output string tag);
    logic [63:0] r;
    int n, off, cls;
    bit hi;
    r   = '0;
    hi  = op[4];
    cls = int'(op[3:2]);
    n   = 1 << op[1:0];
    off = int'(b[2:0]);
    tag = "R11";
    for (int j = 0; j < 8; j++) begin
      logic [7:0] v;
      v = 8'h00;
      case (cls)
        0: if (!hi) begin
          case (op[1:0])
            2'd0: begin tag = "R3";  v = b[j] ? 8'h00 : get_byte(a, j); end
            2'd1: begin tag = "R3";  v = b[j] ? get_byte(a, j) : 8'h00; end
            2'd2: begin tag = "R10"; v = 8'h00; end
            default: v = 8'h00;
          endcase
        end
        1: begin
          tag = hi ? "R5" : "R4";
          if (!hi) v = (j >= off && j < off + n) ? 8'h00 : get_byte(a, j);
          else     v = (j < off + n - 8) ? 8'h00 : get_byte(a, j);
        end
        2: begin
          tag = hi ? "R7" : "R6";
          if (j < n) begin
            if (!hi) v = (j + off < 8) ? get_byte(a, j + off) : 8'h00;
            else if (off == 0) v = get_byte(a, j);
            else v = (j >= 8 - off) ? get_byte(a, j - (8 - off)) : 8'h00;
          end
        end
        default: begin
          tag = hi ? "R9" : "R8";
          if (!hi) v = (j >= off && j - off < n) ? get_byte(a, j - off) : 8'h00;
          else v = (off != 0 && j < off + n - 8) ? get_byte(a, j + 8 - off) : 8'h00;
        end
      endcase
      r[j*8 +: 8] = v;
    end
    if (op == 5'b00010) begin
      for (int j = 0; j < 8; j++) r[j] = (get_byte(a, j) >= get_byte(b, j));
    end
    return r;
  endfunction

  task automatic drive(logic [4:0] op, logic [63:0] a, logic [63:0] b);
    sb_item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_a     = a;
    in_b     = b;
    it.exp   = ref_model(op, a, b, it.tag);
    sb_q.push_back(it);
  endtask

  task automatic idle(int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = 64'hDEAD_BEEF_0BAD_F00D;
      in_op    = 5'b00000;
    end
  endtask

  // Monitor: compares results on the falling edge.
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        checks++;
        if (sb_q.size() == 0) begin
          failures++;
          $display("FAIL R2: out_valid=1 actual, no request pending expected");
        end else begin
          sb_item_t it;
          it = sb_q.pop_front();
          if (out_result !== it.exp) begin
            failures++;
            $display("FAIL %s: result %h actual, %h expected", it.tag, out_result, it.exp);
          end
          last_exp  = it.exp;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        checks++;
        if (out_result !== last_exp) begin
          failures++;
          $display("FAIL R2: idle result %h actual, %h expected", out_result, last_exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run not finished actual, finished expected");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [63:0] PAT_A = 64'h8877_6655_4433_2211;
  localparam logic [63:0] PAT_B = 64'hF0E1_D2C3_B4A5_9687;

  initial begin : stimulus
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (out_valid !== 1'b0 || out_result !== 64'h0) begin
      failures++;
      $display("FAIL R1: valid=%b result=%h actual, 0/0 expected", out_valid, out_result);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;  // R1 after release
    if (out_valid !== 1'b0 || out_result !== 64'h0) begin
      failures++;
      $display("FAIL R1: valid=%b result=%h actual, 0/0 expected", out_valid, out_result);
    end
    running = 1'b1;

    // R3 zap and zap-not over several lane masks.
    drive(5'b00000, PAT_A, 64'h0000_0000_0000_00A5);
    drive(5'b00001, PAT_A, 64'h0000_0000_0000_00A5);
    drive(5'b00000, PAT_A, 64'h0000_0000_0000_00FF);
    drive(5'b00001, PAT_A, 64'h0000_0000_0000_0000);
    idle(2);  // R2 hold after a result

    // R4..R9 every size, every offset, low and high forms.
    for (int cls = 1; cls < 4; cls++) begin
      for (int hi = 0; hi < 2; hi++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int off = 0; off < 8; off++) begin
            drive({hi[0], cls[1:0], sz[1:0]}, PAT_A, {61'h1234_5678_9ABC_DEF, off[2:0]});
          end
          drive({hi[0], cls[1:0], sz[1:0]}, PAT_B, 64'hFFFF_FFFF_FFFF_FFFD);
        end
      end
      idle(1);
    end

    // R10 lane compare: equal, greater, smaller, all-equal, all-smaller.
    drive(5'b00010, PAT_A, 64'h8878_6655_4432_2212);
    drive(5'b00010, PAT_A, PAT_A);
    drive(5'b00010, 64'h0, 64'h0101_0101_0101_0101);
    drive(5'b00010, 64'hFF00_FF00_FF00_FF00, 64'h7F7F_7F7F_7F7F_7F7F);

    // R11 reserved encodings.
    drive(5'b00011, PAT_A, PAT_B);
    for (int s = 0; s < 4; s++) drive({3'b100, s[1:0]}, PAT_A, PAT_B);
    idle(3);

    // Mixed patterns for all opcodes, with gaps.
    for (int t = 0; t < 200; t++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      drive(5'($urandom_range(0, 31)), ra, rb);
      if ((t % 7) == 3) idle(1);
    end
    idle(4);

    running = 1'b0;
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R2: %0d results missing actual, 0 expected", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule